// File: doc/BRIEF.md
# Dual-Slope Temperature Conversion Sequencer

This block sequences a dual-slope integrating temperature converter and counts its result. It runs in a frame of fixed length that repeats. The frame starts by holding the integrator node at its reference level with both current sources disconnected. After a one-clock quiet gap, the temperature-proportional current charges the integrator for a fixed number of clocks. The block then switches to the constant reference current, which discharges the node. It counts clocks until the synchronous comparator reports that the node has fallen below the reference level.

The count of discharge clocks is the temperature code: one count is one degree at the nominal 8 ns clock. A discharge that runs to the top of the code range saturates the result and raises an overflow flag. A one-clock done strobe marks each new result. The switches then stay open until the next frame boundary. The analog front end lies outside the block.

Top module: `dslope_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the precharge phase: `precharge_en`=1, `ptat_en`=0, `ref_en`=0, `done`=0, `result`=0 and `overflow`=0. Reset is synchronous. The frame position after release counts from the reset cycle as position 0.
- R2: `precharge_en` is high for frame positions 0 to INIT_CYCLES-1 and low elsewhere. Neither current enable is high while it is active.
- R3: At position INIT_CYCLES, all three enables are low. This releases the precharge exactly one clock before integration.
- R4: `ptat_en` is high for exactly INT_CYCLES clocks, at positions INIT_CYCLES+1 to INIT_CYCLES+INT_CYCLES.
- R5: `ref_en` rises in the clock right after `ptat_en` falls. The two enables are never high together.
- R6: During discharge, the internal count starts at 0 and advances once per clock. The first discharge clock with `cmp_below`=1 at its closing edge ends the discharge, and `result` takes the count of that clock. A result of k therefore means that `ref_en` was high for k+1 clocks.
- R7: If the count reaches 2^RES_W-1 (511) without a trip, the discharge ends in that clock. `result` becomes 511 and `overflow` becomes 1.
- R8: A trip seen in the same clock that the count reaches 511 gives `result`=511 with `overflow`=0.
- R9: `done` is a one-clock pulse in the clock after the last discharge clock. `result` and `overflow` change only when `done` is high and hold their values otherwise.
- R10: Frames repeat every FRAME_CYCLES clocks. The precharge phase starts again at each frame boundary.
- R11: `cmp_below` is ignored outside the discharge phase. A comparator held high during precharge, gap, integration and idle does not change `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock (8 ns nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_below | input | 1 | Synchronous comparator: integrator node below reference |
| precharge_en | output | 1 | Holds integrator node at reference level |
| ptat_en | output | 1 | Connects temperature-proportional current |
| ref_en | output | 1 | Connects constant reference current |
| result | output | RES_W | Latched temperature code |
| overflow | output | 1 | Discharge saturated without a trip |
| done | output | 1 | One-clock strobe with a new result |

## Verification
The assertions assume that `cmp_below` is already synchronous to `clk`. They also assume that the discharge always finishes inside the frame, which holds for any setting where INIT_CYCLES + INT_CYCLES + 2^RES_W + 2 < FRAME_CYCLES. The stimulus keeps within both assumptions. A behavioural charge model in the bench adds the code value on every integration clock and subtracts INT_CYCLES on every discharge clock. It drives the comparator from the sign of that charge at the falling edge. In chosen frames it drives the comparator high outside discharge to probe R11. The code values cover zero, mid range, both sides of the 511 limit and far overrange.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    PH_PRECHG = 3'd0,
    PH_GAP    = 3'd1,
    PH_CHARGE = 3'd2,
    PH_DISCHG = 3'd3,
    PH_IDLE   = 3'd4
  } phase_e;

  // largest code representable in a result of the given width
  function automatic int code_max(input int width);
    return (1 << width) - 1;
  endfunction

  // clocks needed by a complete frame in the worst case
  function automatic int frame_need(input int init_c, input int int_c, input int width);
    return init_c + 1 + int_c + code_max(width) + 2;
  endfunction

endpackage

// File: rtl/dsc_frame_timer.sv
module dsc_frame_timer #(
  parameter int FRAME_CYCLES = 4000,
  parameter int INIT_CYCLES  = 8,
  parameter int INT_CYCLES   = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic ev_init_last,
  output logic ev_gap,
  output logic ev_charge_last,
  output logic ev_frame_last
);
  localparam int FCNT_W = $clog2(FRAME_CYCLES);
  localparam logic [FCNT_W-1:0] POS_LAST   = FCNT_W'(FRAME_CYCLES - 1);
  localparam logic [FCNT_W-1:0] POS_INIT_L = FCNT_W'(INIT_CYCLES - 1);
  localparam logic [FCNT_W-1:0] POS_GAP    = FCNT_W'(INIT_CYCLES);
  localparam logic [FCNT_W-1:0] POS_CHG_L  = FCNT_W'(INIT_CYCLES + INT_CYCLES);

  logic [FCNT_W-1:0] fpos;

  always_ff @(posedge clk) begin
    if (!rst_n)                fpos <= '0;
    else if (fpos == POS_LAST) fpos <= '0;
    else                       fpos <= fpos + 1'b1;
  end

  assign ev_init_last   = (fpos == POS_INIT_L);
  assign ev_gap         = (fpos == POS_GAP);
  assign ev_charge_last = (fpos == POS_CHG_L);
  assign ev_frame_last  = (fpos == POS_LAST);

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_last |=> (fpos == '0));

endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
  import dsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_init_last,
  input  logic ev_gap,
  input  logic ev_charge_last,
  input  logic ev_frame_last,
  input  logic conv_end,
  output logic in_dischg,
  output logic precharge_en,
  output logic ptat_en,
  output logic ref_en
);
  phase_e phase, phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_PRECHG: if (ev_init_last)   phase_nx = PH_GAP;
      PH_GAP:    if (ev_gap)         phase_nx = PH_CHARGE;
      PH_CHARGE: if (ev_charge_last) phase_nx = PH_DISCHG;
      PH_DISCHG: if (conv_end)       phase_nx = PH_IDLE;
      PH_IDLE:   if (ev_frame_last)  phase_nx = PH_PRECHG;
      default:                       phase_nx = PH_PRECHG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_PRECHG;
    else        phase <= phase_nx;
  end

  assign precharge_en = (phase == PH_PRECHG);
  assign ptat_en      = (phase == PH_CHARGE);
  assign ref_en       = (phase == PH_DISCHG);
  assign in_dischg    = ref_en;

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptat_en) |-> ($past(!precharge_en) && $past(!ref_en)));

  p_dischg_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptat_en) |-> ref_en);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptat_en && ref_en));

  p_prechg_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(precharge_en) |-> $past(ev_frame_last));

endmodule

// File: rtl/dsc_dischg_counter.sv
module dsc_dischg_counter
  import dsc_pkg::*;
#(
  parameter int RES_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_dischg,
  input  logic             cmp_below,
  output logic             conv_end,
  output logic [RES_W-1:0] result,
  output logic             overflow,
  output logic             done
);
  localparam logic [RES_W-1:0] CMAX = RES_W'(code_max(RES_W));

  logic [RES_W-1:0] cnt;
  logic             at_top;

  assign at_top   = (cnt == CMAX);
  assign conv_end = in_dischg && (cmp_below || at_top);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_dischg) cnt <= '0;
    else if (!conv_end)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= conv_end;
      if (conv_end) begin
        result   <= cmp_below ? cnt : CMAX;
        overflow <= !cmp_below;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(overflow)));

  p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result == CMAX));

  p_done_after_dischg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_dischg));

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dsc_pkg::*;
#(
  parameter int FRAME_CYCLES = 4000,
  parameter int INIT_CYCLES  = 8,
  parameter int INT_CYCLES   = 500,
  parameter int RES_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_below,
  output logic             precharge_en,
  output logic             ptat_en,
  output logic             ref_en,
  output logic [RES_W-1:0] result,
  output logic             overflow,
  output logic             done
);
  localparam int NEED = frame_need(INIT_CYCLES, INT_CYCLES, RES_W);

  logic ev_init_last, ev_gap, ev_charge_last, ev_frame_last;
  logic conv_end, in_dischg;

  initial begin
    if (NEED > FRAME_CYCLES) $error("frame too short for worst-case conversion");
  end

  dsc_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .INIT_CYCLES (INIT_CYCLES),
    .INT_CYCLES  (INT_CYCLES)
  ) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_init_last  (ev_init_last),
    .ev_gap        (ev_gap),
    .ev_charge_last(ev_charge_last),
    .ev_frame_last (ev_frame_last)
  );

  dsc_phase_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_init_last  (ev_init_last),
    .ev_gap        (ev_gap),
    .ev_charge_last(ev_charge_last),
    .ev_frame_last (ev_frame_last),
    .conv_end      (conv_end),
    .in_dischg     (in_dischg),
    .precharge_en  (precharge_en),
    .ptat_en       (ptat_en),
    .ref_en        (ref_en)
  );

  dsc_dischg_counter #(.RES_W(RES_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_dischg(in_dischg),
    .cmp_below(cmp_below),
    .conv_end (conv_end),
    .result   (result),
    .overflow (overflow),
    .done     (done)
  );

  p_done_ends_dischg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_en) |-> done);

endmodule

// File: tb/test_dslope_seq.sv
`timescale 1ns/1ps
module test_dslope_seq;
  localparam int FRAME = 4000;
  localparam int INIT  = 8;
  localparam int INTC  = 500;
  localparam int RW    = 9;
  localparam int TOP   = 511;
  localparam int D0    = INIT + 1 + INTC;
  localparam int NFR   = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp_below;
  logic precharge_en, ptat_en, ref_en, overflow, done;
  logic [RW-1:0] result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int temps [NFR] = '{0, 1, 37, 255, 510, 511, 512, 700, 128};
  bit noisy [NFR] = '{0, 0, 1, 0, 0, 0, 0, 1, 0};

  int pos, fi, tcode, charge, exp_res, exp_ovf;
  bit nz;

  always #2 clk = ~clk;

  dslope_seq #(.FRAME_CYCLES(FRAME), .INIT_CYCLES(INIT), .INT_CYCLES(INTC), .RES_W(RW))
    i_dslope_seq (
      .clk(clk), .rst_n(rst_n), .cmp_below(cmp_below),
      .precharge_en(precharge_en), .ptat_en(ptat_en), .ref_en(ref_en),
      .result(result), .overflow(overflow), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s pos=%0d frame=%0d actual=%0d expected=%0d", req, pos, fi, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // compare this cycle's outputs with the model, then drive the comparator
  task automatic step();
    int span, lastc, xpre, xptat, xref, xdone;
    string rq;
    lastc = (tcode > TOP) ? TOP : tcode;
    span  = lastc + 1;
    xpre  = (pos < INIT) ? 1 : 0;
    xptat = (pos >= INIT + 1 && pos <= INIT + INTC) ? 1 : 0;
    xref  = (pos >= D0 && pos < D0 + span) ? 1 : 0;
    xdone = (pos == D0 + span) ? 1 : 0;
    if (xdone == 1) begin
      exp_res = lastc;
      exp_ovf = (tcode > TOP) ? 1 : 0;
    end
    rq = (pos == 0 && fi > 0) ? "R10" : "R2";
    check(int'(precharge_en) == xpre, rq, int'(precharge_en), xpre);
    rq = (pos == INIT) ? "R3" : "R4";
    check(int'(ptat_en) == xptat, rq, int'(ptat_en), xptat);
    rq = (pos == D0) ? "R5" : "R6";
    check(int'(ref_en) == xref, rq, int'(ref_en), xref);
    check(int'(done) == xdone, "R9", int'(done), xdone);
    if (xdone == 1)
      rq = (tcode > TOP) ? "R7" : (tcode == TOP) ? "R8" : nz ? "R11" : "R6";
    else
      rq = "R9";
    check(int'(result) == exp_res, rq, int'(result), exp_res);
    check(int'(overflow) == exp_ovf, (xdone == 1) ? "R7" : "R9", int'(overflow), exp_ovf);
    // behavioural integrator
    if (xpre == 1)  charge = 0;
    if (xptat == 1) charge += tcode;
    if (xref == 1)  charge -= INTC;
    cmp_below = (xref == 1) ? (charge < 0) : nz;
  endtask

  initial begin
    rst_n = 1'b0;
    cmp_below = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(precharge_en == 1'b1, "R1", int'(precharge_en), 1);
    check(ptat_en == 1'b0 && ref_en == 1'b0, "R1", int'(ptat_en) + int'(ref_en), 0);
    check(done == 1'b0 && overflow == 1'b0, "R1", int'(done) + int'(overflow), 0);
    check(result == '0, "R1", int'(result), 0);
    rst_n = 1'b1;
    pos = 0; fi = 0; charge = 0; exp_res = 0; exp_ovf = 0;
    tcode = temps[0]; nz = noisy[0];
    step();
    forever begin
      @(negedge clk);
      pos++;
      if (pos == FRAME) begin
        pos = 0;
        fi++;
        if (fi == NFR) break;
        tcode = temps[fi];
        nz = noisy[fi];
      end
      step();
    end
    finish_run();
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired pos=%0d frame=%0d", pos, fi);
    finish_run();
  end

endmodule